// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block sits between a synchronous read front end and a memory array and produces the word address for every beat of a burst read. A one-cycle start strobe captures a starting word address and one of three burst modes. The modes are an unbounded linear run, a wrapping run over an aligned 8-word group, and a wrapping run over an aligned 16-word group. From then on, each cycle in which the consumer requests a beat and the block signals ready moves the address forward by one position.

The block also produces the ready flag that paces the consumer. In the linear mode, moving into another bank costs a fixed number of latency cycles if that bank is idle. If that bank is busy programming or erasing, the burst stops until its busy input drops. In the 16-word wrap mode, a configured number of wait cycles may be inserted once, when the sequence first passes from one 8-word half of the group to the other. A burst ends when chip enable drops, when reset is asserted, or when a new start strobe arrives.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and directly after it, `active_o` and `ready_o` are 0 and `addr_o` is 0.
- R2: A start strobe with chip enable high makes the next cycle show `addr_o` equal to the captured start address, with `active_o` and `ready_o` both 1. The mode codes are: 0 = linear, 1 = 8-word wrap, 2 = 16-word wrap, 3 = linear.
- R3: In linear mode, each accepted beat (`ready_o` and `adv_i` both high) adds one to the address. From the all-ones address the next address is 0.
- R4: When chip enable is low, the burst is closed from the next cycle on, with `active_o` and `ready_o` at 0. A start strobe given while chip enable is low is ignored and leaves `addr_o` unchanged.
- R5: A start strobe during an active burst abandons that burst and begins the new one from its own start address and mode.
- R6: In 8-word wrap mode, the addresses are the start address's group (start with its low 3 bits cleared) combined with low bits (start + i) mod 8, for i = 0 to 7. After the 8th word the address is held with ready high, and no wait cycle occurs.
- R7: In 16-word wrap mode, the addresses are the group (start with its low 4 bits cleared) combined with low bits (start + i) mod 16, for i = 0 to 15. After the 16th word the address is held, and bits above bit 3 never change during the burst.
- R8: In 16-word wrap mode, the first crossing between 8-word halves holds ready low for `wait_cnt_i` cycles if the start address's low 3 bits are nonzero. If they are zero, there is no stall. The count is sampled with the start strobe.
- R9: Wrap modes never stall on bank crossing or bank busy, whatever `bank_busy_i` shows.
- R10: In linear mode, moving into a different bank whose busy bit is 0 holds ready low for XLAT cycles (default 2). The bank index is the top BANK_BITS bits of the address.
- R11: In linear mode, moving into a bank whose busy bit is 1 shows that bank's first address with ready low for as long as the bit stays 1. Ready returns one cycle after the bit falls.
- R12: The address does not change in any active cycle without an accepted beat (ready or adv low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| start_i | input | 1 | New-address strobe, one cycle |
| start_addr_i | input | ADDR_W | Starting word address |
| mode_i | input | 2 | Burst mode code |
| adv_i | input | 1 | Consumer requests the next beat |
| bank_busy_i | input | 2**BANK_BITS | Per-bank programming/erasing flag |
| wait_cnt_i | input | WAIT_W | Configured half-crossing wait count |
| addr_o | output | ADDR_W | Current word address |
| ready_o | output | 1 | Current address is valid for a beat |
| active_o | output | 1 | A burst is in progress |

## Verification
The properties assume that `mode_i` and `start_addr_i` are meaningful only in the cycle that `start_i` is high. They also assume that a busy bank eventually goes idle, because otherwise a halted linear burst never ends unless chip enable drops. The stimulus never holds a busy bit high indefinitely: it releases the bit after a known number of cycles. It changes mode and address only together with a start strobe, and it drops the advance request before every restart, so each beat in the expected queue maps to exactly one accepted cycle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [1:0] {
        BM_LINEAR  = 2'd0,
        BM_WRAP8   = 2'd1,
        BM_WRAP16  = 2'd2,
        BM_LINALT  = 2'd3
    } bmode_e;

    // Code 3 behaves as a linear burst; fold it so the state holds three modes.
    function automatic bmode_e decode_mode(input logic [1:0] code);
        return (code == 2'd3) ? BM_LINEAR : bmode_e'(code);
    endfunction

endpackage

// File: rtl/bsq_step.sv
module bsq_step
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  bmode_e            mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] next_o,
    output logic              half_flip_o
);

    always_comb begin
        case (mode_i)
            BM_WRAP8:  next_o = {addr_i[ADDR_W-1:3], addr_i[2:0] + 3'd1};
            BM_WRAP16: next_o = {addr_i[ADDR_W-1:4], addr_i[3:0] + 4'd1};
            default:   next_o = addr_i + 1'b1;
        endcase
        half_flip_o = next_o[3] ^ addr_i[3];
    end

endmodule

// File: rtl/bsq_bank_probe.sv
module bsq_bank_probe #(
    parameter int ADDR_W    = 24,
    parameter int BANK_BITS = 2,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [ADDR_W-1:0] next_addr_i,
    input  logic [NBANK-1:0]  bank_busy_i,
    output logic              cross_o,
    output logic              next_busy_o,
    output logic              cur_busy_o
);

    generate
        if (BANK_BITS > 0) begin : g_banked
            logic [BANK_BITS-1:0] cur_bank;
            logic [BANK_BITS-1:0] next_bank;
            assign cur_bank    = cur_addr_i[ADDR_W-1 -: BANK_BITS];
            assign next_bank   = next_addr_i[ADDR_W-1 -: BANK_BITS];
            assign cross_o     = (cur_bank != next_bank);
            assign next_busy_o = bank_busy_i[next_bank];
            assign cur_busy_o  = bank_busy_i[cur_bank];
        end else begin : g_single
            logic unused_addr;
            assign unused_addr = ^{cur_addr_i, next_addr_i};
            assign cross_o     = 1'b0;
            assign next_busy_o = bank_busy_i[0];
            assign cur_busy_o  = bank_busy_i[0];
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BANK_BITS = 2,
    parameter int WAIT_W    = 4,
    parameter int XLAT      = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce_i,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         start_addr_i,
    input  logic [1:0]                mode_i,
    input  logic                      adv_i,
    input  logic [(1<<BANK_BITS)-1:0] bank_busy_i,
    input  logic [WAIT_W-1:0]         wait_cnt_i,
    output logic [ADDR_W-1:0]         addr_o,
    output logic                      ready_o,
    output logic                      active_o
);

    localparam int XW    = $clog2(XLAT + 2);
    localparam int CNT_W = (WAIT_W > XW) ? WAIT_W : XW;

    typedef struct packed {
        logic              active;
        bmode_e            mode;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        words;    // advances taken inside a wrap group
        logic [CNT_W-1:0]  stall;    // latency cycles still to spend
        logic              halt;     // parked on a busy bank
        logic              crossed;  // half boundary already passed
        logic [WAIT_W-1:0] pend;     // stall owed at the half crossing
    } seq_t;

    seq_t st_d, st_q;

    logic [ADDR_W-1:0] nxt_addr;
    logic              half_flip;
    logic              bank_cross;
    logic              next_busy;
    logic              cur_busy;
    logic              ready;
    bmode_e            new_mode;
    bmode_e            cur_mode;
    logic              cur_halt;

    bsq_step #(.ADDR_W(ADDR_W)) u_step (
        .mode_i      (st_q.mode),
        .addr_i      (st_q.addr),
        .next_o      (nxt_addr),
        .half_flip_o (half_flip)
    );

    bsq_bank_probe #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) u_probe (
        .cur_addr_i  (st_q.addr),
        .next_addr_i (nxt_addr),
        .bank_busy_i (bank_busy_i),
        .cross_o     (bank_cross),
        .next_busy_o (next_busy),
        .cur_busy_o  (cur_busy)
    );

    assign new_mode = decode_mode(mode_i);
    assign ready    = st_q.active && (st_q.stall == '0) && !st_q.halt;

    always_comb begin
        st_d = st_q;
        if (!ce_i) begin
            st_d.active = 1'b0;
            st_d.halt   = 1'b0;
            st_d.stall  = '0;
        end else if (start_i) begin
            st_d.active  = 1'b1;
            st_d.mode    = new_mode;
            st_d.addr    = start_addr_i;
            st_d.words   = '0;
            st_d.stall   = '0;
            st_d.halt    = 1'b0;
            st_d.crossed = 1'b0;
            st_d.pend    = ((new_mode == BM_WRAP16) && (start_addr_i[2:0] != 3'd0))
                           ? wait_cnt_i : '0;
        end else if (st_q.active) begin
            if (st_q.stall != '0) begin
                st_d.stall = st_q.stall - 1'b1;
            end else if (st_q.halt) begin
                st_d.halt = cur_busy;
            end else if (adv_i) begin
                case (st_q.mode)
                    BM_WRAP8: begin
                        if (st_q.words < 4'd7) begin
                            st_d.addr  = nxt_addr;
                            st_d.words = st_q.words + 1'b1;
                        end
                    end
                    BM_WRAP16: begin
                        if (st_q.words < 4'd15) begin
                            st_d.addr  = nxt_addr;
                            st_d.words = st_q.words + 1'b1;
                            if (half_flip && !st_q.crossed) begin
                                st_d.crossed = 1'b1;
                                st_d.stall   = CNT_W'(st_q.pend);
                            end
                        end
                    end
                    default: begin
                        st_d.addr = nxt_addr;
                        if (bank_cross) begin
                            if (next_busy) st_d.halt  = 1'b1;
                            else           st_d.stall = CNT_W'(XLAT);
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o   = st_q.addr;
    assign active_o = st_q.active;
    assign ready_o  = ready;
    assign cur_mode = st_q.mode;
    assign cur_halt = st_q.halt;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_i,
    input logic              start_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              ready_o,
    input logic              active_o,
    input bmode_e            mode_q,
    input logic              halt_q
);

    p_ready_in_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> active_o);

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && start_i) |=> (active_o && ready_o && addr_o == $past(start_addr_i)));

    p_ce_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> (!active_o && !ready_o));

    p_hold_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && !start_i && active_o && !(ready_o && adv_i)) |=> $stable(addr_o));

    p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && !start_i && ready_o && adv_i && mode_q == BM_LINEAR)
        |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

    p_wrap_in_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && !start_i && active_o && mode_q != BM_LINEAR)
        |=> addr_o[ADDR_W-1:4] == $past(addr_o[ADDR_W-1:4]));

    p_wrap_no_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && mode_q != BM_LINEAR) |-> !halt_q);

endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W)) u_bsq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_i         (ce_i),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .adv_i        (adv_i),
    .addr_o       (addr_o),
    .ready_o      (ready_o),
    .active_o     (active_o),
    .mode_q       (cur_mode),
    .halt_q       (cur_halt)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int XL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_i = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [1:0]    mode_i = 2'd0;
    logic          adv_i = 1'b0;
    logic [3:0]    bank_busy_i = '0;
    logic [3:0]    wait_cnt_i = '0;
    logic [AW-1:0] addr_o;
    logic          ready_o;
    logic          active_o;

    burst_addr_seq #(.ADDR_W(AW), .BANK_BITS(2), .WAIT_W(4), .XLAT(XL)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .start_i(start_i),
        .start_addr_i(start_addr_i), .mode_i(mode_i), .adv_i(adv_i),
        .bank_busy_i(bank_busy_i), .wait_cnt_i(wait_cnt_i),
        .addr_o(addr_o), .ready_o(ready_o), .active_o(active_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int            nvec = 0;
    int            nfail = 0;
    int            lowcnt = 0;
    string         cur_req = "R0";
    logic [AW-1:0] exp_q[$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: one accepted beat per falling edge with ready and advance high.
    always @(negedge clk) begin
        if (rst_n) begin
            if (active_o && !ready_o) lowcnt++;
            if (active_o && ready_o && adv_i && exp_q.size() > 0) begin
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                check(cur_req, 64'(addr_o), 64'(e));
            end
        end
    end

    task automatic start_burst(input logic [AW-1:0] a, input logic [1:0] m, input string req);
        @(posedge clk); #1;
        ce_i = 1'b1; start_i = 1'b1; start_addr_i = a; mode_i = m; adv_i = 1'b0;
        @(posedge clk); #1;
        start_i = 1'b0;
        cur_req = req;
        check("R2 addr", 64'(addr_o), 64'(a));
        check("R2 active/ready", {62'd0, active_o, ready_o}, 64'd3);
        lowcnt = 0;
        adv_i = 1'b1;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() > 0 && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        if (exp_q.size() > 0) begin
            nfail++;
            $display("FAIL %s: actual %0d beats left expected 0", cur_req, exp_q.size());
            exp_q.delete();
        end
        #1 adv_i = 1'b0;
    endtask

    task automatic end_burst();
        @(posedge clk); #1;
        ce_i = 1'b0; adv_i = 1'b0;
        @(posedge clk); #1;
        check("R4 closed", {62'd0, active_o, ready_o}, 64'd0);
    endtask

    task automatic push_wrap(input logic [AW-1:0] a, input int len, input int extra);
        logic [AW-1:0] base;
        logic [AW-1:0] last;
        base = a & ~AW'(len - 1);
        last = a;
        for (int i = 0; i < len; i++) begin
            last = base | ((a + AW'(i)) & AW'(len - 1));
            exp_q.push_back(last);
        end
        for (int k = 0; k < extra; k++) exp_q.push_back(last);
    endtask

    task automatic push_lin(input logic [AW-1:0] a, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(a + AW'(i));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {38'd0, addr_o, active_o, ready_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {38'd0, addr_o, active_o, ready_o}, 64'd0);

        // R6: byte 3C = word 1E, 8-word group, then held
        push_wrap(24'h1E, 8, 2);
        start_burst(24'h1E, 2'd1, "R6 wrap8");
        drain();
        check("R6 no wait", 64'(lowcnt), 64'd0);
        end_burst();

        // R7/R8: nonzero half offset, wait 3
        wait_cnt_i = 4'd3;
        push_wrap(24'h1E, 16, 1);
        start_burst(24'h1E, 2'd2, "R7 wrap16");
        drain();
        check("R8 stall offset 6", 64'(lowcnt), 64'd3);
        end_burst();

        // R8: zero offset, crossing 27->28
        push_wrap(24'h20, 16, 0);
        start_burst(24'h20, 2'd2, "R7 wrap16 aligned");
        drain();
        check("R8 no stall aligned", 64'(lowcnt), 64'd0);
        end_burst();

        // R8: zero offset in upper half, crossing 2F->20
        wait_cnt_i = 4'd5;
        push_wrap(24'h28, 16, 0);
        start_burst(24'h28, 2'd2, "R7 wrap16 upper");
        drain();
        check("R8 no stall upper half", 64'(lowcnt), 64'd0);
        end_burst();

        // R9: wrap at bank top with all banks busy
        wait_cnt_i = 4'd2;
        bank_busy_i = 4'hF;
        push_wrap(24'h3FFFFF, 16, 0);
        start_burst(24'h3FFFFF, 2'd2, "R9 wrap16 busy banks");
        drain();
        check("R9 only half stall", 64'(lowcnt), 64'd2);
        end_burst();
        bank_busy_i = 4'h0;

        // R3: linear, both codes
        push_lin(24'h100, 10);
        start_burst(24'h100, 2'd0, "R3 linear");
        drain();
        check("R3 no stall", 64'(lowcnt), 64'd0);
        end_burst();
        push_lin(24'h500, 4);
        start_burst(24'h500, 2'd3, "R3 linear code3");
        drain();
        end_burst();

        // R10: idle bank crossing
        push_lin(24'h3FFFFE, 4);
        start_burst(24'h3FFFFE, 2'd0, "R10 idle crossing");
        drain();
        check("R10 crossing latency", 64'(lowcnt), 64'(XL));
        end_burst();

        // R3: top address rolls to 0 (bank 3 -> 0 also costs latency, R10)
        push_lin(24'hFFFFFE, 4);
        start_burst(24'hFFFFFE, 2'd0, "R3 top rollover");
        drain();
        check("R10 rollover latency", 64'(lowcnt), 64'(XL));
        end_burst();

        // R11: busy bank crossing
        bank_busy_i = 4'b0010;
        push_lin(24'h3FFFFE, 4);
        start_burst(24'h3FFFFE, 2'd0, "R11 busy crossing");
        repeat (10) @(posedge clk);
        #1;
        check("R11 halted beats left", 64'(exp_q.size()), 64'd2);
        check("R11 halted address", 64'(addr_o), 64'h400000);
        check("R11 ready low", {63'd0, ready_o}, 64'd0);
        bank_busy_i = 4'b0000;
        drain();
        check("R11 low cycles", 64'(lowcnt), 64'd9);

        // R5: restart while active
        push_lin(24'h100, 3);
        start_burst(24'h100, 2'd0, "R5 first burst");
        drain();
        push_wrap(24'h7005, 8, 0);
        start_burst(24'h7005, 2'd1, "R5 restarted wrap8");
        drain();
        check("R5 no stall", 64'(lowcnt), 64'd0);

        // R12: no advance without request
        begin
            logic [AW-1:0] held;
            held = addr_o;
            repeat (3) @(posedge clk);
            #1;
            check("R12 stable", 64'(addr_o), 64'(held));
        end

        // R4: start ignored while chip enable low
        end_burst();
        begin
            logic [AW-1:0] held;
            held = addr_o;
            start_i = 1'b1; start_addr_i = 24'h55;
            @(posedge clk); #1;
            start_i = 1'b0;
            check("R4 start ignored active", {63'd0, active_o}, 64'd0);
            check("R4 start ignored addr", 64'(addr_o), 64'(held));
        end

        // R1: reset during a burst
        push_lin(24'h900, 2);
        start_burst(24'h900, 2'd0, "R1 pre-reset");
        drain();
        rst_n = 1'b0;
        #1;
        check("R1 mid-burst reset", {38'd0, addr_o, active_o, ready_o}, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule